// File: doc/BRIEF.md
# Supply Rail Undervoltage Filter and Sticky Status Flag

This block watches two internal 2.5 V supply rails, one feeding analog circuits and one feeding digital circuits. An analog comparator for each rail reports whether that rail is below its undervoltage threshold. The block brings both comparator outputs into the clock domain and combines them. It then decides in time whether a fault is present. The fault state is entered only after at least one rail has stayed low for an unbroken filter window. It is left only after both rails have stayed good for an equally long unbroken window. Any interruption of the qualifying condition restarts the count.

Each entry into the fault state sets a sticky status flag. A host processor reads the flag through a one-cycle read strobe, and that read clears it. The filter length is a parameter counted in clock cycles. At a 10 MHz clock the nominal 0.5 µs window is 5 cycles, which is the default.

Top module: `rail_uv_monitor`

## Requirements
- R1: A synchronous active-high reset drives `fault_o` and `flag_o` to 0 and clears the synchroniser stages and the filter counter. Both outputs are 0 at the first clock edge that samples `rst` high.
- R2: Each rail input (1 = rail below threshold) passes through a two-stage synchroniser. With the default window of 5 cycles, a rail input first sampled high at edge 1 and held high makes `fault_o` rise at edge 7 (window + 2).
- R3: Either rail on its own can bring the block into the fault state. A low analog rail with a good digital rail does so, and the reverse does too.
- R4: A rail low for fewer cycles than the window does not enter the fault state. A break of one good cycle restarts the count, so two runs of window − 1 low cycles separated by one good cycle do not enter it. Exactly one full window of low cycles does enter it.
- R5: While one rail is still low, the fault state is held for as long as that lasts. Once in the fault state, a break in the all-good condition restarts the exit count.
- R6: `flag_o` rises at the same edge at which `fault_o` rises. It then stays 1, including after the fault is left, until a read.
- R7: A clock edge that samples `rd_i` high with no new fault entry at that edge clears `flag_o` to 0.
- R8: When a read and a fault entry fall on the same edge, the set wins and `flag_o` stays 1.
- R9: A read while the fault is still present leaves `flag_o` at 0 for the rest of that fault and through its exit. The flag is set again only at the next entry into the fault state.
- R10: With the default window, once both rail inputs are first sampled low (good) at edge 1 and held there, `fault_o` falls at edge 7. Leaving the fault state never sets `flag_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| ana_low_i | input | 1 | Analog rail comparator, 1 = below threshold (asynchronous) |
| dig_low_i | input | 1 | Digital rail comparator, 1 = below threshold (asynchronous) |
| rd_i | input | 1 | Host read strobe for the status flag, one cycle per read |
| fault_o | output | 1 | Filtered undervoltage fault state, registered |
| flag_o | output | 1 | Sticky undervoltage status flag, cleared by a read, registered |

## Verification
Two functions can fall in the same cycle: the filter's entry into the fault state and the host's read-clear of the sticky flag. The bench provokes this collision by holding a rail low and placing the read strobe on exactly the seventh edge, which is the edge where entry completes. It then expects the flag to read 1 afterwards. The neighbouring cases are also driven: a read one edge before entry, and a read during a standing fault. These show that the flag goes to 0 in those cases and comes back only on a fresh entry.

// File: rtl/uvmon_pkg.sv
package uvmon_pkg;

  // Filter state: which condition the counter is currently qualifying
  typedef enum logic {
    RAILS_OK    = 1'b0,
    RAILS_FAULT = 1'b1
  } rail_state_e;

  localparam int NUM_RAILS = 2;
  localparam int RAIL_ANA  = 0;
  localparam int RAIL_DIG  = 1;

endpackage

// File: rtl/uvmon_sync.sv
module uvmon_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  if (STAGES <= 1) begin : g_single
    logic [WIDTH-1:0] stage_q;
    always_ff @(posedge clk) begin
      if (rst) stage_q <= '0;
      else     stage_q <= async_i;
    end
    assign sync_o = stage_q;
  end else begin : g_chain
    logic [STAGES-1:0][WIDTH-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (rst) chain_q <= '0;
      else     chain_q <= {chain_q[STAGES-2:0], async_i};
    end
    assign sync_o = chain_q[STAGES-1];
  end

endmodule

// File: rtl/uvmon_filter.sv
module uvmon_filter
  import uvmon_pkg::*;
#(
  parameter int FILT_CYC = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic any_low_i,
  input  logic all_good_i,
  output logic fault_o,
  output logic enter_o
);

  localparam int CNT_W = (FILT_CYC > 1) ? $clog2(FILT_CYC) : 1;
  localparam logic [CNT_W-1:0] TERM = CNT_W'(FILT_CYC - 1);

  rail_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             qualify;
  logic             hit;

  // In OK the counter times a low run; in FAULT it times a good run
  always_comb begin
    qualify = (state_q == RAILS_OK) ? any_low_i : all_good_i;
    hit     = qualify && (cnt_q == TERM);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RAILS_OK;
      cnt_q   <= '0;
    end else if (!qualify) begin
      cnt_q   <= '0;
    end else if (hit) begin
      cnt_q   <= '0;
      state_q <= (state_q == RAILS_OK) ? RAILS_FAULT : RAILS_OK;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign fault_o = (state_q == RAILS_FAULT);
  assign enter_o = hit && (state_q == RAILS_OK);

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= TERM);  // R4
  AST_ENTER_NEEDS_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_o) |-> $past(any_low_i));  // R3
  AST_EXIT_NEEDS_GOOD: assert property (@(posedge clk) disable iff (rst)
    $fell(fault_o) |-> $past(all_good_i));  // R5
  AST_NO_EARLY_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (!fault_o && (cnt_q != TERM)) |=> !fault_o);  // R4
  AST_HOLD_WHILE_LOW: assert property (@(posedge clk) disable iff (rst)
    (fault_o && any_low_i) |=> fault_o);  // R5

endmodule

// File: rtl/uvmon_flag.sv
module uvmon_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic rd_i,
  output logic flag_o
);

  logic flag_q;

  // Set has priority over the read-clear
  always_ff @(posedge clk) begin
    if (rst)        flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (rd_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o);  // R8
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !set_i) |=> !flag_o);  // R7
  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !rd_i) |=> flag_o);  // R6
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
    (!flag_o && !set_i) |=> !flag_o);  // R9

endmodule

// File: rtl/rail_uv_monitor.sv
module rail_uv_monitor
  import uvmon_pkg::*;
#(
  parameter int FILT_CYC    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ana_low_i,
  input  logic dig_low_i,
  input  logic rd_i,
  output logic fault_o,
  output logic flag_o
);

  logic [NUM_RAILS-1:0] low_async;
  logic [NUM_RAILS-1:0] low_sync;
  logic                 any_low;
  logic                 all_good;
  logic                 enter;

  assign low_async[RAIL_ANA] = ana_low_i;
  assign low_async[RAIL_DIG] = dig_low_i;

  uvmon_sync #(
    .WIDTH  (NUM_RAILS),
    .STAGES (SYNC_STAGES)
  ) i_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (low_async),
    .sync_o  (low_sync)
  );

  assign any_low  = |low_sync;
  assign all_good = ~|low_sync;

  uvmon_filter #(
    .FILT_CYC (FILT_CYC)
  ) i_filter (
    .clk        (clk),
    .rst        (rst),
    .any_low_i  (any_low),
    .all_good_i (all_good),
    .fault_o    (fault_o),
    .enter_o    (enter)
  );

  uvmon_flag i_flag (
    .clk    (clk),
    .rst    (rst),
    .set_i  (enter),
    .rd_i   (rd_i),
    .flag_o (flag_o)
  );

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!fault_o && !flag_o));  // R1
  AST_FLAG_ON_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_o) |-> flag_o);  // R6
  AST_EXIT_NO_SET: assert property (@(posedge clk) disable iff (rst)
    ($fell(fault_o) && $past(!flag_o)) |-> !flag_o);  // R10

endmodule

// File: tb/test_rail_uv_monitor.sv
module test_rail_uv_monitor;

  localparam int CLK_PERIOD = 100;
  localparam int FILT       = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ana = 1'b0;
  logic dig = 1'b0;
  logic rd  = 1'b0;
  logic fault;
  logic flag;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rail_uv_monitor #(.FILT_CYC(FILT), .SYNC_STAGES(2)) i_rail_uv_monitor (
    .clk       (clk),
    .rst       (rst),
    .ana_low_i (ana),
    .dig_low_i (dig),
    .rd_i      (rd),
    .fault_o   (fault),
    .flag_o    (flag)
  );

  typedef struct packed {
    logic       ana;
    logic       dig;
    logic       rd;
    logic [7:0] n;
    logic       e_fault;
    logic       e_flag;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 31;
  // Fields: ana, dig, rd, edges held, expected fault, expected flag, requirement
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b0, 8'd3,  1'b0, 1'b0, 4'd1},  // R1 idle after reset
    '{1'b1, 1'b0, 1'b0, 8'd6,  1'b0, 1'b0, 4'd2},  // R2 not yet at edge 6
    '{1'b1, 1'b0, 1'b0, 8'd1,  1'b1, 1'b1, 4'd2},  // R2 R6 rises at edge 7
    '{1'b0, 1'b0, 1'b0, 8'd6,  1'b1, 1'b1, 4'd10}, // R10 still held at edge 6
    '{1'b0, 1'b0, 1'b0, 8'd1,  1'b0, 1'b1, 4'd10}, // R10 R6 falls, flag sticky
    '{1'b0, 1'b0, 1'b1, 8'd1,  1'b0, 1'b0, 4'd7},  // R7 read clears
    '{1'b0, 1'b1, 1'b0, 8'd4,  1'b0, 1'b0, 4'd4},  // R4 short digital glitch
    '{1'b0, 1'b0, 1'b0, 8'd8,  1'b0, 1'b0, 4'd4},  // R4 glitch rejected
    '{1'b0, 1'b1, 1'b0, 8'd4,  1'b0, 1'b0, 4'd4},  // R4 first run
    '{1'b0, 1'b0, 1'b0, 8'd1,  1'b0, 1'b0, 4'd4},  // R4 one-cycle break
    '{1'b0, 1'b1, 1'b0, 8'd4,  1'b0, 1'b0, 4'd4},  // R4 second run
    '{1'b0, 1'b0, 1'b0, 8'd8,  1'b0, 1'b0, 4'd4},  // R4 restart held off entry
    '{1'b0, 1'b1, 1'b0, 8'd7,  1'b1, 1'b1, 4'd3},  // R3 digital rail alone
    '{1'b1, 1'b1, 1'b0, 8'd3,  1'b1, 1'b1, 4'd3},  // R3 both low
    '{1'b1, 1'b0, 1'b0, 8'd10, 1'b1, 1'b1, 4'd5},  // R5 analog still low holds
    '{1'b1, 1'b0, 1'b1, 8'd1,  1'b1, 1'b0, 4'd9},  // R9 read during fault
    '{1'b1, 1'b0, 1'b0, 8'd5,  1'b1, 1'b0, 4'd9},  // R9 stays clear
    '{1'b0, 1'b0, 1'b0, 8'd7,  1'b0, 1'b0, 4'd9},  // R9 R10 exit does not set
    '{1'b1, 1'b0, 1'b0, 8'd7,  1'b1, 1'b1, 4'd9},  // R9 R3 re-entry sets again
    '{1'b0, 1'b0, 1'b0, 8'd4,  1'b1, 1'b1, 4'd5},  // R5 partial good run
    '{1'b1, 1'b0, 1'b0, 8'd1,  1'b1, 1'b1, 4'd5},  // R5 break
    '{1'b0, 1'b0, 1'b0, 8'd6,  1'b1, 1'b1, 4'd5},  // R5 count restarted
    '{1'b0, 1'b0, 1'b0, 8'd1,  1'b0, 1'b1, 4'd5},  // R5 exit after full window
    '{1'b0, 1'b0, 1'b1, 8'd1,  1'b0, 1'b0, 4'd7},  // R7 clear before collision
    '{1'b1, 1'b0, 1'b0, 8'd6,  1'b0, 1'b0, 4'd8},  // R8 approach entry
    '{1'b1, 1'b0, 1'b1, 8'd1,  1'b1, 1'b1, 4'd8},  // R8 read on entry edge
    '{1'b1, 1'b0, 1'b0, 8'd2,  1'b1, 1'b1, 4'd8},  // R8 flag kept
    '{1'b0, 1'b0, 1'b0, 8'd7,  1'b0, 1'b1, 4'd6},  // R6 sticky past exit
    '{1'b0, 1'b0, 1'b1, 8'd1,  1'b0, 1'b0, 4'd7},  // R7 clear
    '{1'b1, 1'b0, 1'b0, 8'd5,  1'b0, 1'b0, 4'd4},  // R4 exactly one window low
    '{1'b0, 1'b0, 1'b0, 8'd2,  1'b1, 1'b1, 4'd4}   // R4 that window enters
  };

  task automatic check(input string what, input int req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic run(input logic a, input logic d, input logic r, input int n);
    ana = a;
    dig = d;
    rd  = r;
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("fault in reset", 1, fault, 1'b0);  // R1
    check("flag in reset", 1, flag, 1'b0);    // R1
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      run(VECS[i].ana, VECS[i].dig, VECS[i].rd, int'(VECS[i].n));
      check($sformatf("row %0d fault", i), int'(VECS[i].req), fault, VECS[i].e_fault);
      check($sformatf("row %0d flag", i), int'(VECS[i].req), flag, VECS[i].e_flag);
    end
    rd = 1'b0;

    // R1: reset during a standing fault with a rail still low
    ana = 1'b1;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("fault after mid-run reset", 1, fault, 1'b0);
    check("flag after mid-run reset", 1, flag, 1'b0);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R2: latency counted again from the first edge after reset
    run(1'b1, 1'b0, 1'b0, 6);
    check("no fault at edge 6 after reset", 2, fault, 1'b0);
    run(1'b1, 1'b0, 1'b0, 1);
    check("fault at edge 7 after reset", 2, fault, 1'b1);
    check("flag at edge 7 after reset", 6, flag, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule